// File: doc/BRIEF.md
# Serial Bank-Control Register Loader

This block sits behind a CPU write window and builds four 5-bit bank-control registers from a stream of single-bit writes. Each accepted write adds data bit 0 to a staging shift register, starting with the least significant bit. On the fifth accepted write, the gathered value goes into the register chosen by the two address bits that arrive with that write. Those two bits are address bits 14:13 of the CPU bus. The registers are a control word, two character-bank selects and a program-bank select.

A write with data bit 7 set restarts the loader. It drops any partial value and forces the two program-mode bits of the control word high. A write filter guards against read-modify-write instructions, which issue two writes back to back. Every write reloads the filter to 2, and each CPU-cycle tick counts it down. A serial write that arrives while the filter is still counting is dropped.

From the control word the block decodes the program window mode, the character window size and a mirroring code. It also presents the 32 KiB program select and the 8 KiB character select, each with its low bit removed. It does no further bank arithmetic.

Top module: `serial_bank_loader`

## Requirements
- R1: After reset, the control register reads 0x0C and the char-0, char-1 and program registers read 0. The decoded outputs then show prg_mode 1, chr_4k 0 and mirror_code 3.
- R2: A write with wr_data[7]=1 sets ctrl[3:2] to 11 and keeps ctrl[4] and ctrl[1:0]. It leaves the other registers alone and discards any partial value, so the next five accepted serial writes form a fresh value.
- R3: Serial values are collected LSB first: the first accepted write after a restart supplies bit 0 and the fifth supplies bit 4.
- R4: On the fifth accepted serial write, the value goes to the register selected by wr_sel of that write only (0 control, 1 char-0, 2 char-1, 3 program). The value appears on the outputs one clock later.
- R5: No register changes on cycles without a write, and none changes on the first four accepted serial writes.
- R6: A serial write is accepted only if at least two cpu_tick cycles have occurred since the previous write, counting only cycles after that write. Every write reloads the filter, whether it is accepted or ignored. Ignored writes change no register and no collection state.
- R7: A wr_data[7]=1 write takes effect even while the filter is counting, and it reloads the filter.
- R8: prg_mode is 0 (32 KiB switching) when ctrl[3]=0. It is 1 (switchable at 0x8000, last bank fixed at 0xC000) when ctrl[3:2]=11, and 2 (first bank fixed at 0x8000, switchable at 0xC000) when ctrl[3:2]=10.
- R9: chr_4k equals ctrl[4], and chr_sel8 equals chr0[4:1].
- R10: mirror_code equals ctrl[1:0] XOR 3.
- R11: prg_sel32 equals prg[4:1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tick | input | 1 | One pulse per CPU cycle; counts the write filter down |
| wr_en | input | 1 | CPU write strobe into the loader window |
| wr_sel | input | 2 | CPU address bits 14:13 of the write |
| wr_data | input | 8 | CPU write data |
| ctrl | output | 5 | Control register |
| chr0 | output | 5 | Character bank select 0 |
| chr1 | output | 5 | Character bank select 1 |
| prg | output | 5 | Program bank select |
| prg_mode | output | 2 | Decoded program window mode |
| chr_4k | output | 1 | 1: two 4 KiB character banks, 0: one 8 KiB bank |
| mirror_code | output | 2 | Decoded mirroring code |
| prg_sel32 | output | 4 | Program select for 32 KiB mode |
| chr_sel8 | output | 4 | Character select for 8 KiB mode |

## Verification
The hidden collection state (the bit count, the staged bits and the filter count) reaches the ports only when a value is committed. A wrong bit count makes a commit land on the wrong write. A wrong staged bit gives a wrong value. Either fault becomes visible one clock after the fifth write of a sequence, or one clock after the write that commits too early. A filter that releases one cycle early or late changes which of two closely spaced writes is counted, so the bench places writes 0, 1 and 2 ticks apart and also stops the ticks. A faulty restart shows in the value committed after a reset write issued in the middle of a sequence.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  typedef enum logic [1:0] {
    PRG_WIN32     = 2'd0,
    PRG_FIX_LAST  = 2'd1,
    PRG_FIX_FIRST = 2'd2
  } prg_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CHR0 = 2'd1,
    SEL_CHR1 = 2'd2,
    SEL_PRG  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sbl_write_filter.sv
module sbl_write_filter #(
  parameter int RELOAD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic tick,
  output logic busy
);
  localparam int CW = $clog2(RELOAD + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en)
      cnt_d = CW'(RELOAD);
    else if (tick && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/sbl_shift_collector.sv
module sbl_shift_collector #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             restart,
  input  logic             bit_in,
  output logic             commit,
  output logic [REG_W-1:0] commit_val
);
  localparam int CNT_W = $clog2(REG_W);
  localparam int STG_W = REG_W - 1;

  logic [STG_W-1:0] stage_q, stage_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last       = (cnt_q == CNT_W'(REG_W - 1));
  assign commit     = accept && last && !restart;
  assign commit_val = {bit_in, stage_q};

  always_comb begin
    stage_d = stage_q;
    cnt_d   = cnt_q;
    if (restart || commit) begin
      stage_d = '0;
      cnt_d   = '0;
    end else if (accept) begin
      for (int i = 0; i < STG_W; i++)
        if (cnt_q == CNT_W'(i)) stage_d[i] = bit_in;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      cnt_q   <= '0;
    end else begin
      stage_q <= stage_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/sbl_reg_file.sv
module sbl_reg_file #(
  parameter int              REG_W     = 5,
  parameter logic [REG_W-1:0] CTRL_INIT = 5'h0C,
  parameter logic [REG_W-1:0] FORCE_MSK = 5'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [1:0]       commit_sel,
  input  logic [REG_W-1:0] commit_val,
  input  logic             force_mode,
  output logic [REG_W-1:0] ctrl,
  output logic [REG_W-1:0] chr0,
  output logic [REG_W-1:0] chr1,
  output logic [REG_W-1:0] prg
);
  import sbl_pkg::*;
  localparam int NREG = 4;

  logic [REG_W-1:0] bank_q [NREG];
  logic [REG_W-1:0] bank_d [NREG];

  always_comb begin
    for (int i = 0; i < NREG; i++) bank_d[i] = bank_q[i];
    if (force_mode)
      bank_d[SEL_CTRL] = bank_q[SEL_CTRL] | FORCE_MSK;
    else if (commit)
      bank_d[commit_sel] = commit_val;
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [REG_W-1:0] INIT = (g == 0) ? CTRL_INIT : '0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q[g] <= INIT;
        else        bank_q[g] <= bank_d[g];
      end
    end
  endgenerate

  assign ctrl = bank_q[SEL_CTRL];
  assign chr0 = bank_q[SEL_CHR0];
  assign chr1 = bank_q[SEL_CHR1];
  assign prg  = bank_q[SEL_PRG];
endmodule

// File: rtl/sbl_mode_decode.sv
module sbl_mode_decode #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ctrl,
  input  logic [REG_W-1:0] chr0,
  input  logic [REG_W-1:0] prg,
  output logic [1:0]       prg_mode,
  output logic             chr_4k,
  output logic [1:0]       mirror_code,
  output logic [REG_W-2:0] prg_sel32,
  output logic [REG_W-2:0] chr_sel8
);
  import sbl_pkg::*;

  always_comb begin
    if (!ctrl[3])     prg_mode = PRG_WIN32;
    else if (ctrl[2]) prg_mode = PRG_FIX_LAST;
    else              prg_mode = PRG_FIX_FIRST;
  end

  assign chr_4k      = ctrl[4];
  assign mirror_code = ctrl[1:0] ^ 2'b11;
  assign prg_sel32   = prg[REG_W-1:1];
  assign chr_sel8    = chr0[REG_W-1:1];
endmodule

// File: rtl/serial_bank_loader.sv
module serial_bank_loader #(
  parameter int DATA_W        = 8,
  parameter int REG_W         = 5,
  parameter int FILTER_RELOAD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [REG_W-1:0] ctrl,
  output logic [REG_W-1:0] chr0,
  output logic [REG_W-1:0] chr1,
  output logic [REG_W-1:0] prg,
  output logic [1:0]       prg_mode,
  output logic             chr_4k,
  output logic [1:0]       mirror_code,
  output logic [REG_W-2:0] prg_sel32,
  output logic [REG_W-2:0] chr_sel8
);
  logic rst_meta, rst_sync;
  logic flt_busy, restart_wr, serial_ok, commit;
  logic [REG_W-1:0] commit_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign restart_wr = wr_en && wr_data[DATA_W-1];
  assign serial_ok  = wr_en && !wr_data[DATA_W-1] && !flt_busy;

  sbl_write_filter #(.RELOAD(FILTER_RELOAD)) u_flt (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .tick(cpu_tick), .busy(flt_busy)
  );

  sbl_shift_collector #(.REG_W(REG_W)) u_col (
    .clk(clk), .rst_n(rst_sync), .accept(serial_ok), .restart(restart_wr),
    .bit_in(wr_data[0]), .commit(commit), .commit_val(commit_val)
  );

  sbl_reg_file #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_sync), .commit(commit), .commit_sel(wr_sel),
    .commit_val(commit_val), .force_mode(restart_wr),
    .ctrl(ctrl), .chr0(chr0), .chr1(chr1), .prg(prg)
  );

  sbl_mode_decode #(.REG_W(REG_W)) u_dec (
    .ctrl(ctrl), .chr0(chr0), .prg(prg), .prg_mode(prg_mode), .chr_4k(chr_4k),
    .mirror_code(mirror_code), .prg_sel32(prg_sel32), .chr_sel8(chr_sel8)
  );
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker #(
  parameter int DATA_W = 8,
  parameter int REG_W  = 5
) (
  input logic              clk,
  input logic              rst_sync,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              flt_busy,
  input logic [REG_W-1:0]  ctrl,
  input logic [REG_W-1:0]  chr0,
  input logic [REG_W-1:0]  chr1,
  input logic [REG_W-1:0]  prg,
  input logic [1:0]        prg_mode
);
  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    !wr_en |=> $stable({ctrl, chr0, chr1, prg}));

  assert_filter_drop_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    (wr_en && !wr_data[DATA_W-1] && flt_busy) |=> $stable({ctrl, chr0, chr1, prg}));

  assert_restart_force_R2: assert property (@(posedge clk) disable iff (!rst_sync)
    (wr_en && wr_data[DATA_W-1]) |=> (ctrl[3:2] == 2'b11) && $stable({chr0, chr1, prg}));

  assert_restart_filtered_R7: assert property (@(posedge clk) disable iff (!rst_sync)
    (wr_en && wr_data[DATA_W-1]) |=> flt_busy);

  assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_sync)
    $countones({ctrl != $past(ctrl), chr0 != $past(chr0),
                chr1 != $past(chr1), prg != $past(prg)}) <= 1);

  assert_mode_legal_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    prg_mode != 2'd3);
endmodule

bind serial_bank_loader sbl_checker #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_sync(rst_sync), .wr_en(wr_en), .wr_data(wr_data),
  .flt_busy(flt_busy), .ctrl(ctrl), .chr0(chr0), .chr1(chr1), .prg(prg),
  .prg_mode(prg_mode)
);

// File: tb/tb_serial_bank_loader.sv
module tb_serial_bank_loader;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] ctrl, chr0, chr1, prg;
  logic [1:0] prg_mode, mirror_code;
  logic chr_4k;
  logic [3:0] prg_sel32, chr_sel8;

  serial_bank_loader dut (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl(ctrl), .chr0(chr0), .chr1(chr1), .prg(prg),
    .prg_mode(prg_mode), .chr_4k(chr_4k), .mirror_code(mirror_code),
    .prg_sel32(prg_sel32), .chr_sel8(chr_sel8)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    due;
    string tag;
    logic [4:0] e_ctrl, e_chr0, e_chr1, e_prg;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [4:0] m_ctrl = 5'h0C, m_chr0 = '0, m_chr1 = '0, m_prg = '0;
  logic [3:0] m_stage = '0;
  int m_cnt = 0;
  int since = 2;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [1:0] exp_mode(input logic [4:0] c);
    if (!c[3]) return 2'd0;
    return c[2] ? 2'd1 : 2'd2;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic check_all(input exp_t e);
    cmp(e.tag, "ctrl", ctrl, e.e_ctrl);
    cmp(e.tag, "chr0", chr0, e.e_chr0);
    cmp(e.tag, "chr1", chr1, e.e_chr1);
    cmp(e.tag, "prg", prg, e.e_prg);
    cmp({e.tag, "/R8"}, "prg_mode", prg_mode, exp_mode(e.e_ctrl));
    cmp({e.tag, "/R9"}, "chr_4k", chr_4k, e.e_ctrl[4]);
    cmp({e.tag, "/R9"}, "chr_sel8", chr_sel8, e.e_chr0[4:1]);
    cmp({e.tag, "/R10"}, "mirror_code", mirror_code, e.e_ctrl[1:0] ^ 2'b11);
    cmp({e.tag, "/R11"}, "prg_sel32", prg_sel32, e.e_prg[4:1]);
  endtask

  // monitor: pops expectations whose register edge has passed
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      check_all(e);
    end
  end

  task automatic idle(input int n, input logic tk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      cpu_tick = tk;
      if (tk) since++;
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; cpu_tick = 1'b1;
    if (d[7]) begin
      m_stage = '0; m_cnt = 0; m_ctrl[3:2] = 2'b11;
    end else if (since >= 2) begin
      if (m_cnt == 4) begin
        case (sel)
          2'd0: m_ctrl = {d[0], m_stage};
          2'd1: m_chr0 = {d[0], m_stage};
          2'd2: m_chr1 = {d[0], m_stage};
          default: m_prg = {d[0], m_stage};
        endcase
        m_stage = '0; m_cnt = 0;
      end else begin
        m_stage[m_cnt] = d[0];
        m_cnt++;
      end
    end
    since = 0;
    e.due = cyc + 1; e.tag = tag;
    e.e_ctrl = m_ctrl; e.e_chr0 = m_chr0; e.e_chr1 = m_chr1; e.e_prg = m_prg;
    q.push_back(e);
  endtask

  task automatic load5(input logic [1:0] first_sel, input logic [1:0] last_sel,
                       input logic [4:0] v, input string tag);
    for (int i = 0; i < 5; i++) begin
      wr((i == 4) ? last_sel : first_sel, {7'b0, v[i]}, tag);
      idle(2, 1'b1);
    end
  endtask

  initial begin
    exp_t e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    e0.due = 0; e0.tag = "R1";
    e0.e_ctrl = 5'h0C; e0.e_chr0 = 0; e0.e_chr1 = 0; e0.e_prg = 0;
    check_all(e0);

    // R3 / R5: LSB-first collection into each register
    load5(2'd3, 2'd3, 5'b10110, "R3_prg");
    load5(2'd1, 2'd1, 5'b10011, "R3_chr0");
    load5(2'd2, 2'd2, 5'b01010, "R5_chr1");
    // R4: only the fifth write's select matters
    load5(2'd1, 2'd2, 5'b11101, "R4_sel_last");
    load5(2'd0, 2'd3, 5'b00111, "R4_prg");
    // R8/R10: control word variants
    load5(2'd0, 2'd0, 5'b01000, "R8_fixfirst");
    load5(2'd0, 2'd0, 5'b00101, "R8_win32");
    load5(2'd0, 2'd0, 5'b11110, "R9_chr4k");
    load5(2'd0, 2'd0, 5'b00001, "R10_mirror");

    // R2: restart in the middle of a sequence
    wr(2'd1, 8'h01, "R2_pre"); idle(2, 1'b1);
    wr(2'd1, 8'h01, "R2_pre"); idle(2, 1'b1);
    wr(2'd0, 8'h80, "R2_restart"); idle(2, 1'b1);
    load5(2'd1, 2'd1, 5'b00100, "R2_fresh");

    // R6: writes too close together are ignored
    wr(2'd3, 8'h01, "R6_a");
    wr(2'd3, 8'h00, "R6_b2b");
    idle(1, 1'b1);
    wr(2'd3, 8'h01, "R6_gap1");
    idle(2, 1'b0);
    wr(2'd3, 8'h01, "R6_noticks");
    idle(2, 1'b1);
    wr(2'd3, 8'h01, "R6_gap2"); idle(2, 1'b1);
    wr(2'd3, 8'h00, "R6_c"); idle(2, 1'b1);
    wr(2'd3, 8'h01, "R6_d"); idle(2, 1'b1);
    wr(2'd3, 8'h01, "R6_commit"); idle(2, 1'b1);

    // R7: restart honoured during filter, and reloads it
    load5(2'd0, 2'd0, 5'b00000, "R7_setup");
    wr(2'd2, 8'h01, "R7_ser");
    wr(2'd0, 8'h80, "R7_restart_busy");
    wr(2'd2, 8'h01, "R7_after_restart");
    idle(1, 1'b1);
    wr(2'd2, 8'h01, "R7_still_busy");
    idle(2, 1'b1);
    load5(2'd2, 2'd2, 5'b11011, "R7_fresh");
    idle(4, 1'b1);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule